// File: doc/BRIEF.md
# Buck Converter PWM / Pulse-Skip Mode Controller

This block makes the per-cycle switching decisions for a peak current-mode step-down converter. In pulse-width mode, each switching-clock pulse turns the high-side switch on. The high side turns off when the modulator comparator or the current-limit comparator trips, and the low-side switch then conducts. A zero crossing of the inductor current, seen while the high side is off, turns the low side off. With no setpoint change pending, that same zero crossing moves the controller into pulse-skip mode.

In pulse-skip mode both switches stay off. The loop-enable output drops so that the error amplifier, the modulator and the current sensor can power down, and the output is left to droop. The controller wakes when the output-low comparator fires or when a setpoint change is requested. It then runs a fixed number of forced switching cycles, ten by default. After those cycles it returns to skip mode if a zero crossing was seen during them, and otherwise it stays in pulse-width mode. Pulse-width mode is held for as long as the setpoint-change request is asserted.

All inputs are sampled on the system clock. All outputs are registered, so they follow their causes by one clock.

Top module: `buck_mode_ctrl`

## Requirements
- R1: After reset, `hs_gate` and `ls_gate` are 0, `mode_o` is 0 (pulse-width mode) and `loop_en` is 1.
- R2: In pulse-width mode (`mode_o`=0) or forced-wake mode (`mode_o`=2), a `cyc_pulse` with no trip in the same cycle sets `hs_gate` and clears `ls_gate` one clock later.
- R3: A `mod_trip` or `ilim_trip` clears `hs_gate` one clock later and wins over a simultaneous `cyc_pulse`. If `hs_gate` was 1, the trip also sets `ls_gate` one clock later.
- R4: `hs_gate` and `ls_gate` are never 1 in the same cycle.
- R5: A `zero_cross` is accepted only while `hs_gate` is 0 and `cyc_pulse` is 0. An accepted zero crossing clears `ls_gate` one clock later. A zero crossing while `hs_gate` is 1 has no effect on the gates.
- R6: In pulse-width mode, an accepted zero crossing with `force_pwm` low moves `mode_o` to 1 (skip mode) one clock later. In skip mode, `loop_en` is 0, both gates are 0 and `cyc_pulse` is ignored.
- R7: In skip mode, `vout_low` or `force_pwm` moves `mode_o` to 2 (forced wake) one clock later and restarts the forced-cycle count.
- R8: In forced wake, the first `FORCE_CYC` (default 10) clock pulses are counted. The next pulse ends the wake. If a zero crossing was accepted during the wake and `force_pwm` is low, `mode_o` goes to 1 and that pulse does not turn the high side on. Otherwise `mode_o` goes to 0 and the pulse acts as in R2.
- R9: While `force_pwm` is 1 in pulse-width mode, `mode_o` never moves to skip mode. A zero crossing still clears `ls_gate` in the default variant (`ZC_IN_FORCE`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_pulse | input | 1 | Start-of-switching-period pulse |
| mod_trip | input | 1 | Peak-current modulator comparator trip |
| ilim_trip | input | 1 | Current-limit comparator trip |
| zero_cross | input | 1 | Inductor current zero-crossing detect |
| vout_low | input | 1 | Output below setpoint comparator |
| force_pwm | input | 1 | Setpoint-change request, forces pulse-width mode |
| hs_gate | output | 1 | High-side switch drive |
| ls_gate | output | 1 | Low-side switch drive |
| loop_en | output | 1 | Enable for loop blocks (0 = powered down) |
| mode_o | output | 2 | Mode: 0 pulse-width, 1 skip, 2 forced wake |

## Verification
A corrupted mode register shows at the ports one clock later, either as a dropped `loop_en` or as a clock pulse that fails to raise `hs_gate`. A forced-cycle count that is off by one shifts the wake exit by one switching period, so `mode_o` leaves 2 one pulse early or one pulse late. A lost zero-crossing flag sends the controller to pulse-width mode instead of skip mode at the end of the wake. The bench keeps a cycle model that is built from the requirements and compares all four outputs after every clock. Directed sequences aim at the wake exit, trip-over-pulse priority and setpoint-forced operation.

// File: rtl/buck_mode_pkg.sv
package buck_mode_pkg;

   typedef enum logic [1:0] {
      MODE_PWM  = 2'd0,
      MODE_SKIP = 2'd1,
      MODE_WAKE = 2'd2
   } bmc_mode_e;

endpackage

// File: rtl/bmc_force_cnt.sv
module bmc_force_cnt #(
   parameter int FORCE_CYC = 10,
   parameter int CNT_W     = $clog2(FORCE_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wake_evt,
   input  logic in_wake,
   input  logic pulse,
   input  logic zc_ok,
   output logic cnt_done,
   output logic zc_seen
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(FORCE_CYC);

   logic [CNT_W-1:0] cnt_q;
   logic             seen_q;

   initial begin
      assert (FORCE_CYC >= 1) else $error("FORCE_CYC must be at least 1");
      assert ((1 << CNT_W) > FORCE_CYC) else $error("CNT_W too narrow for FORCE_CYC");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (wake_evt) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (in_wake) begin
         if (pulse && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
         if (zc_ok) seen_q <= 1'b1;
      end else begin
         cnt_q <= '0;
      end
   end

   assign cnt_done = (cnt_q == LAST);
   assign zc_seen  = seen_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST); // R8

   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/bmc_mode_seq.sv
module bmc_mode_seq
   import buck_mode_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pulse,
   input  logic      zc_ok,
   input  logic      force_pwm,
   input  logic      vout_low,
   input  logic      cnt_done,
   input  logic      zc_seen,
   output bmc_mode_e mode,
   output logic      go_skip,
   output logic      wake_end_skip,
   output logic      wake_evt
);

   bmc_mode_e mode_q, mode_d;
   logic      wake_done;

   assign wake_evt      = (mode_q == MODE_SKIP) && (vout_low || force_pwm);
   assign wake_done     = (mode_q == MODE_WAKE) && pulse && cnt_done;
   assign wake_end_skip = wake_done && zc_seen && !force_pwm;
   assign go_skip       = ((mode_q == MODE_PWM) && zc_ok && !force_pwm) || wake_end_skip;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_PWM:  if (go_skip)   mode_d = MODE_SKIP;
         MODE_SKIP: if (wake_evt)  mode_d = MODE_WAKE;
         MODE_WAKE: if (wake_done) mode_d = wake_end_skip ? MODE_SKIP : MODE_PWM;
         default:                  mode_d = MODE_PWM;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_PWM;
      else        mode_q <= mode_d;
   end

   assign mode = mode_q;

   AST_WAKE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_SKIP) && (vout_low || force_pwm) |=> (mode_q == MODE_WAKE)); // R7

   AST_FORCE_HOLDS_PWM: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_PWM) && force_pwm |=> (mode_q != MODE_SKIP)); // R9

   AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q != 2'd3); // R6

endmodule

// File: rtl/bmc_gate_latch.sv
module bmc_gate_latch #(
   parameter bit ZC_IN_FORCE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_set,
   input  logic trip,
   input  logic zc_ok,
   input  logic force_pwm,
   input  logic go_skip,
   output logic hs_q,
   output logic ls_q
);

   logic zc_clear;

   generate
      if (ZC_IN_FORCE) begin : g_zc_always
         assign zc_clear = zc_ok;
      end else begin : g_zc_ccm
         assign zc_clear = zc_ok && !force_pwm;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q <= 1'b0;
         ls_q <= 1'b0;
      end else if (go_skip) begin
         hs_q <= 1'b0;
         ls_q <= 1'b0;
      end else begin
         if (trip)        hs_q <= 1'b0;
         else if (hs_set) hs_q <= 1'b1;

         if (hs_set)              ls_q <= 1'b0;
         else if (trip && hs_q)   ls_q <= 1'b1;
         else if (zc_clear)       ls_q <= 1'b0;
      end
   end

   AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_q && ls_q)); // R4

   AST_TRIP_CLEARS_HS: assert property (@(posedge clk) disable iff (!rst_n)
      trip |=> !hs_q); // R3

   AST_TRIP_HANDS_LS: assert property (@(posedge clk) disable iff (!rst_n)
      trip && hs_q && !go_skip |=> ls_q); // R3

endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl
   import buck_mode_pkg::*;
#(
   parameter int FORCE_CYC   = 10,
   parameter bit ZC_IN_FORCE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cyc_pulse,
   input  logic       mod_trip,
   input  logic       ilim_trip,
   input  logic       zero_cross,
   input  logic       vout_low,
   input  logic       force_pwm,
   output logic       hs_gate,
   output logic       ls_gate,
   output logic       loop_en,
   output logic [1:0] mode_o
);

   localparam int CNT_W = $clog2(FORCE_CYC + 1);

   bmc_mode_e mode;
   logic trip, zc_ok, hs_q, ls_q, hs_set;
   logic go_skip, wake_end_skip, wake_evt, cnt_done, zc_seen;

   assign trip   = mod_trip || ilim_trip;
   assign zc_ok  = zero_cross && !hs_q && !cyc_pulse;
   assign hs_set = cyc_pulse && (mode != MODE_SKIP) && !trip && !wake_end_skip;

   bmc_mode_seq u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .pulse         (cyc_pulse),
      .zc_ok         (zc_ok),
      .force_pwm     (force_pwm),
      .vout_low      (vout_low),
      .cnt_done      (cnt_done),
      .zc_seen       (zc_seen),
      .mode          (mode),
      .go_skip       (go_skip),
      .wake_end_skip (wake_end_skip),
      .wake_evt      (wake_evt)
   );

   bmc_force_cnt #(.FORCE_CYC(FORCE_CYC), .CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .wake_evt (wake_evt),
      .in_wake  (mode == MODE_WAKE),
      .pulse    (cyc_pulse),
      .zc_ok    (zc_ok),
      .cnt_done (cnt_done),
      .zc_seen  (zc_seen)
   );

   bmc_gate_latch #(.ZC_IN_FORCE(ZC_IN_FORCE)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .hs_set    (hs_set),
      .trip      (trip),
      .zc_ok     (zc_ok),
      .force_pwm (force_pwm),
      .go_skip   (go_skip),
      .hs_q      (hs_q),
      .ls_q      (ls_q)
   );

   assign hs_gate = hs_q;
   assign ls_gate = ls_q;
   assign loop_en = (mode != MODE_SKIP);
   assign mode_o  = mode;

   AST_PULSE_SETS_HS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_PWM) && cyc_pulse && !trip |=> hs_gate); // R2

   AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_SKIP) |-> (!hs_gate && !ls_gate && !loop_en)); // R6

   AST_ZC_IGNORED_HS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      hs_gate && zero_cross && !trip && !cyc_pulse |=> hs_gate); // R5

endmodule

// File: tb/sim_buck_mode_ctrl.sv
module sim_buck_mode_ctrl;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_pulse = 0, mod_trip = 0, ilim_trip = 0, zero_cross = 0, vout_low = 0, force_pwm = 0;
   logic hs_gate, ls_gate, loop_en;
   logic [1:0] mode_o;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // Model state built from the requirements
   bit m_hs, m_ls, m_zcs;
   int m_mode, m_cnt;
   localparam int FC = 10;

   always #2 clk = ~clk;

   buck_mode_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cyc_pulse(cyc_pulse), .mod_trip(mod_trip),
      .ilim_trip(ilim_trip), .zero_cross(zero_cross), .vout_low(vout_low),
      .force_pwm(force_pwm), .hs_gate(hs_gate), .ls_gate(ls_gate),
      .loop_en(loop_en), .mode_o(mode_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit zc_accept(bit z, bit p, bit hs);
      return z && !hs && !p;
   endfunction

   task automatic model_step(bit p, bit t, bit z, bit v, bit f);
      bit zc, wdone, to_skip, go_skip, hs_set;
      bit n_hs, n_ls, n_zcs;
      int n_mode, n_cnt;
      zc      = zc_accept(z, p, m_hs);
      wdone   = (m_mode == 2) && p && (m_cnt == FC);
      to_skip = wdone && m_zcs && !f;
      go_skip = ((m_mode == 0) && zc && !f) || to_skip;
      hs_set  = p && (m_mode != 1) && !t && !to_skip;
      n_hs = go_skip ? 0 : t ? 0 : hs_set ? 1 : m_hs;
      n_ls = go_skip ? 0 : hs_set ? 0 : (t && m_hs) ? 1 : zc ? 0 : m_ls;
      n_mode = m_mode; n_cnt = m_cnt; n_zcs = m_zcs;
      if (m_mode == 1 && (v || f)) begin n_mode = 2; n_cnt = 0; n_zcs = 0; end
      else if (m_mode == 2) begin
         if (p && m_cnt < FC) n_cnt = m_cnt + 1;
         if (zc) n_zcs = 1;
         if (wdone) n_mode = to_skip ? 1 : 0;
      end else if (m_mode == 0 && go_skip) n_mode = 1;
      if (n_mode != 2 && m_mode != 1) n_cnt = 0;
      m_hs = n_hs; m_ls = n_ls; m_mode = n_mode; m_cnt = n_cnt; m_zcs = n_zcs;
   endtask

   task automatic cyc(bit p, bit mt, bit it, bit z, bit v, bit f);
      cyc_pulse = p; mod_trip = mt; ilim_trip = it; zero_cross = z; vout_low = v; force_pwm = f;
      @(posedge clk);
      model_step(p, mt || it, z, v, f);
      #1;
      chk("R2 hs_gate", hs_gate, m_hs);
      chk("R3 ls_gate", ls_gate, m_ls);
      chk("R8 mode_o", mode_o, m_mode);
      chk("R6 loop_en", loop_en, (m_mode != 1));
      chk("R4 exclusive", hs_gate && ls_gate, 0);
   endtask

   initial begin
      #100000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int seed = 32'h5eed_1234;
      void'($urandom(seed));
      m_hs = 0; m_ls = 0; m_zcs = 0; m_mode = 0; m_cnt = 0;
      #9; rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 hs", hs_gate, 0); chk("R1 ls", ls_gate, 0);
      chk("R1 mode", mode_o, 0); chk("R1 loop_en", loop_en, 1);

      // R2 pulse turns high side on
      cyc(1,0,0,0,0,0); chk("R2 on", hs_gate, 1);
      // R5 zero cross while high side on is ignored
      cyc(0,0,0,1,0,0); chk("R5 zc ignored hs", hs_gate, 1); chk("R5 mode", mode_o, 0);
      // R3 trip hands over to low side
      cyc(0,1,0,0,0,0); chk("R3 hs off", hs_gate, 0); chk("R3 ls on", ls_gate, 1);
      // R3 trip wins over pulse
      cyc(1,0,1,0,0,0); chk("R3 priority", hs_gate, 0);
      // R9 force blocks skip entry, ls still cleared
      cyc(0,0,0,1,0,1); chk("R9 mode", mode_o, 0); chk("R9 ls", ls_gate, 0);
      cyc(1,0,0,0,0,0); cyc(0,1,0,0,0,0);
      // R6 zero cross enters skip
      cyc(0,0,0,1,0,0); chk("R6 mode", mode_o, 1); chk("R6 loop_en", loop_en, 0);
      cyc(1,0,0,0,0,0); chk("R6 pulse ignored", hs_gate, 0);
      // R7 wake
      cyc(0,0,0,0,1,0); chk("R7 mode", mode_o, 2);
      // R8 ten forced cycles without zero cross -> pulse-width
      for (int k = 0; k < FC; k++) begin
         cyc(1,0,0,0,0,0); cyc(0,1,0,0,0,0); cyc(0,0,0,0,0,0);
      end
      chk("R8 still wake", mode_o, 2);
      cyc(1,0,0,0,0,0); chk("R8 to pwm", mode_o, 0); chk("R8 hs", hs_gate, 1);
      // back to skip, wake, then see a zero cross -> skip again
      cyc(0,1,0,0,0,0); cyc(0,0,0,1,0,0); cyc(0,0,0,0,0,1);
      chk("R7 force wakes", mode_o, 2);
      for (int k = 0; k < FC; k++) begin
         cyc(1,0,0,0,0,0); cyc(0,1,0,0,0,0); cyc(0,0,0,k == 4,0,0);
      end
      cyc(1,0,0,0,0,0); chk("R8 to skip", mode_o, 1); chk("R8 no hs", hs_gate, 0);

      // Constrained random
      for (int n = 0; n < 20000; n++) begin
         cyc(($urandom % 8) == 0, ($urandom % 10) == 0, ($urandom % 25) == 0,
             ($urandom % 9) == 0, ($urandom % 20) == 0, ($urandom % 40) == 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule